// File: doc/BRIEF.md
# Banked Register File

This block holds several equal banks of general-purpose registers behind a narrow register address. A small bank pointer chooses which bank every read and write lands in, so the total number of registers grows with the bank count while the address field carried by each access stays the same width. The pointer changes only when a dedicated bank-select command is presented. Ordinary accesses never move it.

A per-bank in-use mask drives registered power-enable outputs. A bank whose enable is low is treated as shut off, and its contents are lost. Once powered again, its registers read zero until each one is written. Writes aimed at an unpowered bank are discarded, and a one-cycle error pulse reports each such write. The block has two combinational read ports and one synchronous write port.

Top module: `bank_regfile`

## Requirements
- R1: While reset is held and on the first cycle after it, the pointer selects bank 0, only bank 0 is powered (`bank_pwr_en` = 0001 with 4 banks), `wr_drop_err` is low, and every read returns zero.
- R2: An access with register address `a` reaches register `a` of the bank named by the pointer. The 3-bit address together with the 2-bit bank pointer covers 32 registers of 16 bits.
- R3: The pointer loads `sel_bank` at the clock edge where `sel_valid` is high, and holds its value at every other edge, whatever reads or writes happen.
- R4: When a bank-select command and a write occur in the same cycle, the write goes to the previously selected bank. The new bank applies from the next cycle.
- R5: Both read ports are combinational. Each returns the selected bank's register in the same cycle its address is driven. A write becomes visible from the cycle after its clock edge.
- R6: `bank_pwr_en[b]` takes the value of `bank_in_use[b]` one clock edge later.
- R7: A write whose target bank has its power enable low changes no register. `wr_drop_err` is high in the single cycle after that write, and low after any cycle without such a write.
- R8: Once a bank has had its power enable low at a clock edge, all of its registers read zero after it is powered again, until each register is written anew.
- R9: A write changes only the addressed register of the selected bank. Every other register in every bank keeps its value.
- R10: A read while the selected bank is unpowered returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_valid | input | 1 | Bank-select command strobe |
| sel_bank | input | 2 | Bank number loaded by the command |
| bank_in_use | input | 4 | Mask of banks to keep powered |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register address within the selected bank for the write |
| wr_data | input | 16 | Write data |
| rd0_addr | input | 3 | Register address for read port 0 |
| rd0_data | output | 16 | Read port 0 data |
| rd1_addr | input | 3 | Register address for read port 1 |
| rd1_data | output | 16 | Read port 1 data |
| bank_pwr_en | output | 4 | Per-bank power enable |
| wr_drop_err | output | 1 | Pulses after a write to an unpowered bank |

## Verification
The assertions assume `sel_bank` always names an existing bank. They also assume that the clock edges after reset release are the only history the block has. Because the default bank count is a power of two, every pointer value is legal. The stimulus draws bank numbers only from that range. It also toggles the in-use mask often enough that banks are gated, written while gated, and re-powered. This lets the data-loss and error-pulse rules be tested against a behavioural model that tracks every register, along with its valid state, on every cycle.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;

  // Width of an index into n things, never less than one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bank_ptr.sv
module bank_ptr #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = bank_rf_pkg::idx_w(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_valid,
  input  logic [BANK_W-1:0] sel_bank,
  output logic [BANK_W-1:0] cur_bank
);

  always_ff @(posedge clk) begin
    if (rst)            cur_bank <= '0;
    else if (sel_valid) cur_bank <= sel_bank;
  end

  // R3: a command loads the requested bank
  p_ptr_load_r3: assert property (@(posedge clk) disable iff (rst)
    sel_valid |=> (cur_bank == $past(sel_bank)));

  // R3: without a command the pointer holds
  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !sel_valid |=> $stable(cur_bank));

endmodule

// File: rtl/bank_power.sv
module bank_power #(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] in_use,
  output logic [NUM_BANKS-1:0] pwr_en
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic RST_ON = (b == 0);

    always_ff @(posedge clk) begin
      if (rst) pwr_en[b] <= RST_ON;
      else     pwr_en[b] <= in_use[b];
    end

    // R6: the enable follows the mask one edge later
    p_pwr_follow_r6: assert property (@(posedge clk) disable iff (rst)
      pwr_en[b] == $past(in_use[b]) || $past(rst));
  end

endmodule

// File: rtl/bank_store.sv
module bank_store #(
  parameter int REGS   = 8,
  parameter int DATA_W = 16,
  localparam int ADDR_W = bank_rf_pkg::idx_w(REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_en,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr0,
  output logic [DATA_W-1:0] rdata0,
  input  logic [ADDR_W-1:0] raddr1,
  output logic [DATA_W-1:0] rdata1
);

  logic [DATA_W-1:0] mem [REGS];
  logic [REGS-1:0]   vld;

  // Storage with no reset so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Per-register valid bits model the loss of contents when gated.
  always_ff @(posedge clk) begin
    if (rst || !pwr_en) vld <= '0;
    else if (we)        vld[waddr] <= 1'b1;
  end

  assign rdata0 = (pwr_en && vld[raddr0]) ? mem[raddr0] : '0;
  assign rdata1 = (pwr_en && vld[raddr1]) ? mem[raddr1] : '0;

  // R7: writes never reach a gated bank
  p_no_gated_write_r7: assert property (@(posedge clk) disable iff (rst)
    we |-> pwr_en);

  // R8: after a gated edge nothing old can be read back
  p_gated_clears_r8: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |=> (rdata0 == '0 && rdata1 == '0));

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile #(
  parameter int NUM_BANKS = 4,
  parameter int REGS      = 8,
  parameter int DATA_W    = 16,
  localparam int BANK_W = bank_rf_pkg::idx_w(NUM_BANKS),
  localparam int ADDR_W = bank_rf_pkg::idx_w(REGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel_valid,
  input  logic [BANK_W-1:0]    sel_bank,
  input  logic [NUM_BANKS-1:0] bank_in_use,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd0_addr,
  output logic [DATA_W-1:0]    rd0_data,
  input  logic [ADDR_W-1:0]    rd1_addr,
  output logic [DATA_W-1:0]    rd1_data,
  output logic [NUM_BANKS-1:0] bank_pwr_en,
  output logic                 wr_drop_err
);

  logic [BANK_W-1:0]    cur_bank;
  logic [NUM_BANKS-1:0] bank_we;
  logic [DATA_W-1:0]    rdat0 [NUM_BANKS];
  logic [DATA_W-1:0]    rdat1 [NUM_BANKS];
  logic                 tgt_on;

  bank_ptr #(.NUM_BANKS(NUM_BANKS)) u_ptr (
    .clk(clk), .rst(rst), .sel_valid(sel_valid),
    .sel_bank(sel_bank), .cur_bank(cur_bank)
  );

  bank_power #(.NUM_BANKS(NUM_BANKS)) u_pwr (
    .clk(clk), .rst(rst), .in_use(bank_in_use), .pwr_en(bank_pwr_en)
  );

  assign tgt_on = bank_pwr_en[cur_bank];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_we[b] = wr_en && (cur_bank == BANK_W'(b)) && bank_pwr_en[b];

    bank_store #(.REGS(REGS), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst(rst), .pwr_en(bank_pwr_en[b]), .we(bank_we[b]),
      .waddr(wr_addr), .wdata(wr_data),
      .raddr0(rd0_addr), .rdata0(rdat0[b]),
      .raddr1(rd1_addr), .rdata1(rdat1[b])
    );
  end

  assign rd0_data = rdat0[cur_bank];
  assign rd1_data = rdat1[cur_bank];

  always_ff @(posedge clk) begin
    if (rst) wr_drop_err <= 1'b0;
    else     wr_drop_err <= wr_en && !tgt_on;
  end

  // R9: at most one bank takes a write per cycle
  p_one_bank_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_we));

  // R7: a dropped write raises the flag next cycle
  p_err_raise_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !bank_pwr_en[cur_bank]) |=> wr_drop_err);

  // R7: the flag only follows a write
  p_err_cause_r7: assert property (@(posedge clk) disable iff (rst)
    wr_drop_err |-> $past(wr_en));

  // R10: an unpowered selected bank reads as zero
  p_off_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !bank_pwr_en[cur_bank] |-> (rd0_data == '0 && rd1_data == '0));

endmodule

// File: tb/bank_regfile_bench.sv
module bank_regfile_bench;

  localparam int NB = 4;
  localparam int NR = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          sel_valid;
  logic [1:0]    sel_bank;
  logic [NB-1:0] bank_in_use;
  logic          wr_en;
  logic [2:0]    wr_addr;
  logic [DW-1:0] wr_data;
  logic [2:0]    rd0_addr, rd1_addr;
  logic [DW-1:0] rd0_data, rd1_data;
  logic [NB-1:0] bank_pwr_en;
  logic          wr_drop_err;

  int checks = 0;
  int fails  = 0;

  // Behavioural reference state
  logic [DW-1:0] m_mem [NB][NR];
  bit            m_vld [NB][NR];
  bit [NB-1:0]   m_pwr;
  int            m_cur;
  bit            m_err;

  always #4 clk = ~clk;

  bank_regfile u_bank_regfile (
    .clk(clk), .rst(rst), .sel_valid(sel_valid), .sel_bank(sel_bank),
    .bank_in_use(bank_in_use), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data), .bank_pwr_en(bank_pwr_en),
    .wr_drop_err(wr_drop_err)
  );

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                     input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] m_read(input int a);
    return (m_pwr[m_cur] && m_vld[m_cur][a]) ? m_mem[m_cur][a] : '0;
  endfunction

  task automatic drive(input bit sv, input int sb, input bit we,
                       input int wa, input logic [DW-1:0] wd,
                       input int ra0, input int ra1);
    sel_valid = sv; sel_bank = 2'(sb);
    wr_en = we; wr_addr = 3'(wa); wr_data = wd;
    rd0_addr = 3'(ra0); rd1_addr = 3'(ra1);
  endtask

  // Compare against the model, take one edge, advance the model.
  task automatic tick();
    bit          n_err;
    bit [NB-1:0] n_pwr;
    #1;
    chk(rd0_data, m_read(int'(rd0_addr)), "R2 R5 read port 0");
    chk(rd1_data, m_read(int'(rd1_addr)), "R2 R5 read port 1");
    chk({12'd0, bank_pwr_en}, {12'd0, m_pwr}, "R6 power enables");
    chk({15'd0, wr_drop_err}, {15'd0, m_err}, "R7 drop flag");
    @(posedge clk);
    n_err = wr_en && !m_pwr[m_cur];
    if (wr_en && m_pwr[m_cur]) begin
      m_mem[m_cur][wr_addr] = wr_data;
      m_vld[m_cur][wr_addr] = 1'b1;
    end
    for (int b = 0; b < NB; b++)
      if (!m_pwr[b]) for (int r = 0; r < NR; r++) m_vld[b][r] = 1'b0;
    n_pwr = bank_in_use;
    if (sel_valid) m_cur = int'(sel_bank);
    m_pwr = n_pwr;
    m_err = n_err;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    bank_in_use = 4'b0001;
    drive(0, 0, 0, 0, '0, 0, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < NR; r++) begin m_vld[b][r] = 0; m_mem[b][r] = '0; end
    m_pwr = 4'b0001; m_cur = 0; m_err = 0;

    // R1: state right after reset
    #1;
    chk({12'd0, bank_pwr_en}, 16'h0001, "R1 reset power");
    chk({15'd0, wr_drop_err}, 16'h0000, "R1 reset flag");
    chk(rd0_data, 16'h0000, "R1 reset read");

    // R2 R5: write bank 0 reg 3, read it back next cycle
    drive(0, 0, 1, 3, 16'h1111, 3, 2); tick();
    drive(0, 0, 0, 0, '0, 3, 2); #1;
    chk(rd0_data, 16'h1111, "R5 written value visible");
    chk(rd1_data, 16'h0000, "R9 neighbour untouched");
    tick();

    // R6: power up bank 1
    bank_in_use = 4'b0011;
    drive(0, 0, 0, 0, '0, 3, 3); tick();
    chk({12'd0, bank_pwr_en}, 16'h0003, "R6 bank 1 powered");

    // R4: select bank 1 with a write in the same cycle
    drive(1, 1, 1, 3, 16'h2222, 3, 3); tick();
    drive(0, 0, 0, 0, '0, 3, 3); #1;
    chk(rd0_data, 16'h0000, "R4 new bank empty");
    tick();
    drive(0, 0, 1, 3, 16'hABCD, 3, 3); tick();
    // R3: several non-command cycles keep bank 1
    drive(0, 2, 0, 0, '0, 3, 3); tick();
    drive(0, 3, 1, 5, 16'h0505, 3, 5); #1;
    chk(rd0_data, 16'hABCD, "R3 pointer held");
    tick();
    drive(1, 0, 0, 0, '0, 3, 3); tick();
    drive(0, 0, 0, 0, '0, 3, 5); #1;
    chk(rd0_data, 16'h2222, "R4 write went to old bank");
    chk(rd1_data, 16'h0000, "R9 bank 1 write stayed in bank 1");
    tick();

    // R7 R10: select unpowered bank 2 and write
    drive(1, 2, 0, 0, '0, 0, 0); tick();
    drive(0, 0, 1, 1, 16'h7777, 1, 1); #1;
    chk(rd0_data, 16'h0000, "R10 unpowered bank reads zero");
    tick();
    drive(0, 0, 0, 0, '0, 1, 1); #1;
    chk({15'd0, wr_drop_err}, 16'h0001, "R7 flag pulses");
    tick();
    chk({15'd0, wr_drop_err}, 16'h0000, "R7 flag one cycle");
    bank_in_use = 4'b0111;
    drive(0, 0, 0, 0, '0, 1, 1); tick();
    drive(0, 0, 0, 0, '0, 1, 1); #1;
    chk(rd0_data, 16'h0000, "R7 dropped write left nothing");
    tick();

    // R8: gate bank 1 then restore it
    bank_in_use = 4'b0101;
    drive(0, 0, 0, 0, '0, 3, 5); tick();
    tick();
    bank_in_use = 4'b0111;
    drive(1, 1, 0, 0, '0, 3, 5); tick();
    drive(0, 0, 0, 0, '0, 3, 5); #1;
    chk(rd0_data, 16'h0000, "R8 contents lost");
    chk(rd1_data, 16'h0000, "R8 contents lost reg 5");
    tick();

    // Mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      if ((i % 37) == 0) bank_in_use = 4'($urandom);
      drive(($urandom % 6) == 0, int'($urandom % 4), ($urandom % 2) == 0,
            int'($urandom % 8), 16'($urandom),
            int'($urandom % 8), int'($urandom % 8));
      tick();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule